// File: doc/BRIEF.md
# Main-memory address and data scrambler

This block sits on the path between a processor's memory request and a single-port, byte-writable main RAM. On the way to the RAM it rewrites the word address through a keyed bijection and XOR-masks each stored word with a key-dependent mask. On the way back it removes the same mask from read data. A dump of the raw RAM array therefore shows neither where a logical word lives nor its plaintext value. The processor sees an ordinary memory, because a read of an address returns exactly what was last written there under the same keys.

The address and data transforms are combinational. The RAM port is driven in the same cycle as the processor request, so no wait state is added. The only register on the data path holds the read mask for the one cycle of RAM read latency.

Keys come from an external random source through a load port. Two key sets are held, one for firmware context and one for application context. The context input selects which set is active, so the mapping changes whenever execution crosses between the two contexts. Key loads are accepted only in firmware context. Both sets clear on reset, so fresh keys must be loaded after every start.

Top module: `ram_scrambler`

## Requirements
- R1: After reset both key sets are zero. With zero keys, `ram_addr` equals the fixed permutation of `cpu_addr`, and `ram_wdata` equals `cpu_wdata` XOR the address tweak of that physical address.
- R2: `ram_addr` is P(`cpu_addr` XOR address key). Bit i of P(x) is bit (i*STRIDE mod ADDR_W) of x. The defaults are ADDR_W=10 and STRIDE=3. The mapping is a bijection: all 2^ADDR_W logical addresses reach distinct physical addresses.
- R3: `ram_wdata` is `cpu_wdata` XOR data key XOR T(phys). Bit j of T(phys) is bit (j mod ADDR_W) of the physical address. For non-zero keys, the raw stored word differs from the logical word.
- R4: The RAM returns read data one cycle after the request. In the cycle after a read request, `cpu_rdata` equals `ram_rdata` XOR the mask of that request's physical address and keys. A write followed by a read of the same logical address, under unchanged keys, returns the written value.
- R5: `ram_en`, `ram_we` and `ram_wstrb` equal `cpu_en`, `cpu_we` and `cpu_wstrb` in the same cycle. `ram_addr` and `ram_wdata` follow a new request in the same cycle, with no register in that path.
- R6: A `seed_load` pulse in firmware context (`mode_app`=0) stores `seed_akey` and `seed_dkey` into the set chosen by `seed_sel`: 0 selects firmware, 1 selects application. The new keys take effect from the next cycle. With no load, the keys hold their values.
- R7: `seed_load` while `mode_app`=1 changes neither key set.
- R8: `mode_app`=0 makes the firmware set active and `mode_app`=1 makes the application set active. The change applies in the same cycle that `mode_app` changes.
- R9: Byte lanes are masked independently. A write with a partial strobe changes only the enabled bytes, and a later full read returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_app | input | 1 | Context: 0 firmware, 1 application |
| seed_load | input | 1 | Key load strobe |
| seed_sel | input | 1 | Key set to load: 0 firmware, 1 application |
| seed_akey | input | ADDR_W | Address key value to load |
| seed_dkey | input | DATA_W | Data key value to load |
| cpu_en | input | 1 | Processor request valid |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_wstrb | input | DATA_W/8 | Byte-lane write enables |
| cpu_addr | input | ADDR_W | Logical word address |
| cpu_wdata | input | DATA_W | Logical write data |
| cpu_rdata | output | DATA_W | Unmasked read data, one cycle after the request |
| ram_en | output | 1 | RAM enable |
| ram_we | output | 1 | RAM write enable |
| ram_wstrb | output | DATA_W/8 | RAM byte-lane enables |
| ram_addr | output | ADDR_W | Physical word address |
| ram_wdata | output | DATA_W | Masked write data |
| ram_rdata | input | DATA_W | Raw read data from RAM |

## Verification
Suppose a key register picks up a stray value or misses a load. The next request then shows a `ram_addr` or `ram_wdata` that differs from the value the bench computes from the keys it loaded. Because the request path is combinational, this appears in the same cycle as the request. A stale or misaligned read mask does not appear at the RAM port. It appears one cycle after a read, as a `cpu_rdata` that does not match what was written earlier. Only a write-then-read sequence under stable keys exposes it. A permutation that is not a bijection stays hidden until two logical addresses are found to share a physical word, so the bench sweeps the whole address range.

// File: rtl/scr_pkg.sv
package scr_pkg;

   typedef enum logic {
      CTX_FW  = 1'b0,
      CTX_APP = 1'b1
   } scr_ctx_e;

   localparam int unsigned SCR_BANKS = 2;

   function automatic int unsigned scr_gcd(input int unsigned a, input int unsigned b);
      int unsigned x;
      int unsigned y;
      int unsigned t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

endpackage

// File: rtl/scr_key_bank.sv
module scr_key_bank
   import scr_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_app,
   input  logic              load,
   input  logic              sel,
   input  logic [ADDR_W-1:0] akey_in,
   input  logic [DATA_W-1:0] dkey_in,
   output logic [ADDR_W-1:0] act_akey,
   output logic [DATA_W-1:0] act_dkey
);

   logic [ADDR_W-1:0] akey_q [SCR_BANKS];
   logic [DATA_W-1:0] dkey_q [SCR_BANKS];
   logic              load_ok;

   assign load_ok = load && (scr_ctx_e'(mode_app) == CTX_FW);

   for (genvar b = 0; b < SCR_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            akey_q[b] <= '0;
            dkey_q[b] <= '0;
         end else if (load_ok && (int'(sel) == b)) begin
            akey_q[b] <= akey_in;
            dkey_q[b] <= dkey_in;
         end
      end
   end

   always_comb begin
      if (scr_ctx_e'(mode_app) == CTX_APP) begin
         act_akey = akey_q[1];
         act_dkey = dkey_q[1];
      end else begin
         act_akey = akey_q[0];
         act_dkey = dkey_q[0];
      end
   end

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= 1'b0;
      else        seen_q <= 1'b1;
   end

   p_keys_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> (akey_q[0] == '0 && akey_q[1] == '0 && dkey_q[0] == '0 && dkey_q[1] == '0))
      else $error("key sets not cleared by reset");

   p_load_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(akey_q[0]) && $stable(akey_q[1]) && $stable(dkey_q[0]) && $stable(dkey_q[1])))
      else $error("key changed without a load");

   p_app_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_app |=> ($stable(akey_q[0]) && $stable(akey_q[1]) && $stable(dkey_q[0]) && $stable(dkey_q[1])))
      else $error("key changed in application context");

endmodule

// File: rtl/scr_addr_map.sv
module scr_addr_map
   import scr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned STRIDE  = 3,
   parameter bit          PERMUTE = 1'b1
) (
   input  logic [ADDR_W-1:0] logical,
   input  logic [ADDR_W-1:0] akey,
   output logic [ADDR_W-1:0] phys
);

   if (ADDR_W < 2) begin : g_chk_w
      $error("ADDR_W must be at least 2");
   end
   if (PERMUTE && scr_gcd(STRIDE, ADDR_W) != 1) begin : g_chk_stride
      $error("STRIDE must be coprime with ADDR_W for a bijective map");
   end

   logic [ADDR_W-1:0] keyed;
   assign keyed = logical ^ akey;

   if (PERMUTE) begin : g_perm
      for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
         localparam int unsigned SRC = (i * STRIDE) % ADDR_W;
         assign phys[i] = keyed[SRC];
      end
   end else begin : g_xor_only
      assign phys = keyed;
   end

endmodule

// File: rtl/scr_data_mask.sv
module scr_data_mask #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RD_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] phys,
   input  logic [DATA_W-1:0] dkey,
   input  logic              rd_req,
   input  logic [DATA_W-1:0] wdata_in,
   output logic [DATA_W-1:0] wdata_out,
   input  logic [DATA_W-1:0] rdata_in,
   output logic [DATA_W-1:0] rdata_out
);

   localparam int unsigned LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_chk_dw
      $error("DATA_W must be a non-zero multiple of 8");
   end
   if (RD_LAT > 1) begin : g_chk_lat
      $error("RD_LAT must be 0 or 1");
   end

   logic [DATA_W-1:0] tweak;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] rmask;

   for (genvar j = 0; j < DATA_W; j++) begin : g_tweak
      assign tweak[j] = phys[j % ADDR_W];
   end
   assign mask = dkey ^ tweak;

   if (RD_LAT == 1) begin : g_rd_reg
      logic [DATA_W-1:0] rmask_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      rmask_q <= '0;
         else if (rd_req) rmask_q <= mask;
      end
      assign rmask = rmask_q;

      p_rmask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_req |=> $stable(rmask_q))
         else $error("read mask moved without a read");
   end else begin : g_rd_comb
      assign rmask = mask;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign wdata_out[l*8 +: 8] = wdata_in[l*8 +: 8] ^ mask[l*8 +: 8];
      assign rdata_out[l*8 +: 8] = rdata_in[l*8 +: 8] ^ rmask[l*8 +: 8];
   end

endmodule

// File: rtl/ram_scrambler.sv
module ram_scrambler #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned STRIDE  = 3,
   parameter bit          PERMUTE = 1'b1,
   parameter int unsigned RD_LAT  = 1,
   localparam int unsigned STRB_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_app,
   input  logic              seed_load,
   input  logic              seed_sel,
   input  logic [ADDR_W-1:0] seed_akey,
   input  logic [DATA_W-1:0] seed_dkey,
   input  logic              cpu_en,
   input  logic              cpu_we,
   input  logic [STRB_W-1:0] cpu_wstrb,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              ram_en,
   output logic              ram_we,
   output logic [STRB_W-1:0] ram_wstrb,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata
);

   logic [ADDR_W-1:0] act_akey;
   logic [DATA_W-1:0] act_dkey;
   logic [ADDR_W-1:0] phys;

   scr_key_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) keys_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_app (mode_app),
      .load     (seed_load),
      .sel      (seed_sel),
      .akey_in  (seed_akey),
      .dkey_in  (seed_dkey),
      .act_akey (act_akey),
      .act_dkey (act_dkey)
   );

   scr_addr_map #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .PERMUTE(PERMUTE)) amap_i (
      .logical (cpu_addr),
      .akey    (act_akey),
      .phys    (phys)
   );

   scr_data_mask #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT)) dmask_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .phys      (phys),
      .dkey      (act_dkey),
      .rd_req    (cpu_en && !cpu_we),
      .wdata_in  (cpu_wdata),
      .wdata_out (ram_wdata),
      .rdata_in  (ram_rdata),
      .rdata_out (cpu_rdata)
   );

   assign ram_addr  = phys;
   assign ram_en    = cpu_en;
   assign ram_we    = cpu_we;
   assign ram_wstrb = cpu_wstrb;

endmodule

// File: tb/ram_scrambler_tb_top.sv
module ram_scrambler_tb_top;

   localparam int AW = 10;
   localparam int DW = 32;
   localparam int SW = DW / 8;
   localparam int ST = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          mode_app = 1'b0;
   logic          seed_load = 1'b0;
   logic          seed_sel = 1'b0;
   logic [AW-1:0] seed_akey = '0;
   logic [DW-1:0] seed_dkey = '0;
   logic          cpu_en = 1'b0;
   logic          cpu_we = 1'b0;
   logic [SW-1:0] cpu_wstrb = '0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          ram_en;
   logic          ram_we;
   logic [SW-1:0] ram_wstrb;
   logic [AW-1:0] ram_addr;
   logic [DW-1:0] ram_wdata;
   logic [DW-1:0] ram_rdata;

   ram_scrambler dut_i (
      .clk(clk), .rst_n(rst_n), .mode_app(mode_app), .seed_load(seed_load),
      .seed_sel(seed_sel), .seed_akey(seed_akey), .seed_dkey(seed_dkey),
      .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_wstrb(cpu_wstrb), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_en(ram_en), .ram_we(ram_we),
      .ram_wstrb(ram_wstrb), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata)
   );

   // Bench-owned RAM model: one-cycle read latency, byte strobes.
   logic [DW-1:0] ram_mem [DEPTH];
   logic [DW-1:0] rdata_q = '0;
   assign ram_rdata = rdata_q;
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) begin
            for (int l = 0; l < SW; l++)
               if (ram_wstrb[l]) ram_mem[ram_addr][l*8 +: 8] <= ram_wdata[l*8 +: 8];
         end else begin
            rdata_q <= ram_mem[ram_addr];
         end
      end
   end

   int n_checks = 0;
   int n_fail = 0;
   logic [DW-1:0] logical [DEPTH];
   logic [AW-1:0] cur_ak = '0;
   logic [DW-1:0] cur_dk = '0;

   function automatic logic [AW-1:0] perm(input logic [AW-1:0] x);
      logic [AW-1:0] r;
      for (int i = 0; i < AW; i++) r[i] = x[(i * ST) % AW];
      return r;
   endfunction

   function automatic logic [DW-1:0] tweak(input logic [AW-1:0] p);
      logic [DW-1:0] r;
      for (int j = 0; j < DW; j++) r[j] = p[j % AW];
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Scoreboard
   logic [DW-1:0] exp_q [$];
   string         tag_q [$];
   logic          rd_flag = 1'b0;
   always @(posedge clk) rd_flag <= cpu_en && !cpu_we;
   always @(negedge clk) begin
      if (rd_flag) begin
         if (exp_q.size() == 0) begin
            chk("R4 unexpected read", 64'd1, 64'd0);
         end else begin
            logic [DW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, {32'd0, cpu_rdata}, {32'd0, e});
         end
      end
   end

   task automatic idle();
      @(posedge clk); #1;
      cpu_en = 1'b0; cpu_we = 1'b0; seed_load = 1'b0;
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [SW-1:0] s);
      logic [AW-1:0] p;
      logic [DW-1:0] m;
      @(posedge clk); #1;
      seed_load = 1'b0;
      cpu_en = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_wstrb = s;
      #1;
      p = perm(a ^ cur_ak);
      m = d ^ cur_dk ^ tweak(p);
      chk("R2 write address", {54'd0, ram_addr}, {54'd0, p});
      chk("R3 write data", {32'd0, ram_wdata}, {32'd0, m});
      chk("R5 strobe/enable pass", {59'd0, ram_en, ram_we, ram_wstrb}, {59'd0, 1'b1, 1'b1, s});
      for (int l = 0; l < SW; l++)
         if (s[l]) logical[a][l*8 +: 8] = d[l*8 +: 8];
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      @(posedge clk); #1;
      seed_load = 1'b0;
      cpu_en = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_wstrb = '0;
      exp_q.push_back(logical[a]);
      tag_q.push_back(tag);
   endtask

   task automatic load(input logic sel, input logic [AW-1:0] ak, input logic [DW-1:0] dk);
      @(posedge clk); #1;
      cpu_en = 1'b0;
      seed_load = 1'b1; seed_sel = sel; seed_akey = ak; seed_dkey = dk;
   endtask

   logic [AW-1:0] addrs [16];
   logic [DW-1:0] datas [16];
   logic          hit [DEPTH];

   initial begin
      repeat (500000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin ram_mem[i] = '0; logical[i] = '0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: zero keys after reset
      wr(10'd5, 32'hA5A5_1234, 4'hF);
      #1 chk("R1 zero-key address", {54'd0, ram_addr}, {54'd0, perm(10'd5)});
      chk("R1 zero-key data", {32'd0, ram_wdata}, {32'd0, 32'hA5A5_1234 ^ tweak(perm(10'd5))});
      idle();

      // R6: load firmware keys, effective next cycle
      load(1'b0, 10'h2B7, 32'hC3D2_E1F0);
      idle();
      cur_ak = 10'h2B7; cur_dk = 32'hC3D2_E1F0;
      for (int i = 0; i < 16; i++) begin
         addrs[i] = AW'((i * 67 + 13) % DEPTH);
         datas[i] = 32'h1357_9BDF * (i + 1) + 32'h0F0F_0F0F;
         wr(addrs[i], datas[i], 4'hF);
      end
      idle();
      // R3: raw stored word differs from logical for non-zero keys
      chk("R3 raw differs", {63'd0, ram_mem[perm(addrs[3] ^ cur_ak)] != datas[3]}, 64'd1);
      chk("R3 raw content", {32'd0, ram_mem[perm(addrs[3] ^ cur_ak)]},
          {32'd0, datas[3] ^ cur_dk ^ tweak(perm(addrs[3] ^ cur_ak))});
      // R4: round trip, back-to-back reads
      for (int i = 0; i < 16; i++) rd(addrs[i], "R4 round trip");
      idle();
      idle();

      // R9: partial writes
      wr(10'd100, 32'h1122_3344, 4'hF);
      wr(10'd100, 32'hAABB_CCDD, 4'b0101);
      wr(10'd101, 32'hFFFF_FFFF, 4'hF);
      wr(10'd101, 32'h0000_0000, 4'b1000);
      idle();
      rd(10'd100, "R9 partial merge lanes 0,2");
      rd(10'd101, "R9 partial merge lane 3");
      idle();
      idle();
      chk("R9 model value", {32'd0, logical[100]}, {32'd0, 32'h11BB_33DD});

      // R2: bijection sweep
      for (int i = 0; i < DEPTH; i++) hit[i] = 1'b0;
      begin
         int coll;
         int mis;
         coll = 0; mis = 0;
         for (int a = 0; a < DEPTH; a++) begin
            @(posedge clk); #1;
            cpu_en = 1'b0; cpu_addr = AW'(a);
            #1;
            if (hit[ram_addr]) coll++;
            hit[ram_addr] = 1'b1;
            if (ram_addr !== perm(AW'(a) ^ cur_ak)) mis++;
         end
         chk("R2 no address collision", 64'(coll), 64'd0);
         chk("R2 map formula over range", 64'(mis), 64'd0);
      end

      // R6: load application set while in firmware context
      load(1'b1, 10'h15A, 32'h0BAD_F00D);
      idle();
      // firmware set still active (R8)
      wr(10'd7, 32'h7777_0000, 4'hF);
      idle();
      // R8: switch to application context, same cycle
      @(posedge clk); #1;
      mode_app = 1'b1; cpu_en = 1'b0; cpu_addr = 10'd7;
      #1 chk("R8 app keys active same cycle", {54'd0, ram_addr}, {54'd0, perm(10'd7 ^ 10'h15A)});
      cur_ak = 10'h15A; cur_dk = 32'h0BAD_F00D;
      wr(10'd200, 32'hDEAD_BEEF, 4'hF);
      wr(10'd201, 32'h0102_0304, 4'hF);
      idle();
      rd(10'd200, "R8 app round trip");
      rd(10'd201, "R8 app round trip");
      idle();
      idle();

      // R7: load attempt in application context is ignored
      load(1'b1, 10'h3FF, 32'hFFFF_0000);
      idle();
      load(1'b0, 10'h001, 32'h0000_FFFF);
      idle();
      wr(10'd202, 32'h5555_AAAA, 4'hF);
      idle();
      #1 chk("R7 app keys unchanged (addr)", {54'd0, ram_addr}, {54'd0, perm(10'd202 ^ 10'h15A)});
      rd(10'd200, "R7 app data still readable");
      idle();
      idle();

      // R8: back to firmware context, firmware set unchanged by ignored load
      @(posedge clk); #1;
      mode_app = 1'b0;
      cur_ak = 10'h2B7; cur_dk = 32'hC3D2_E1F0;
      wr(10'd300, 32'hCAFE_0001, 4'hF);
      idle();
      rd(10'd300, "R8 firmware round trip");
      idle();
      idle();
      chk("R4 scoreboard drained", 64'(exp_q.size()), 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule